// File: doc/BRIEF.md
# Serial Converter Sample Reader

This block runs on the host side of a three-wire serial link to a sampling converter. It fetches one 16-bit sample per frame. It derives a slow serial clock from the system clock and frames each transfer with an active-low select. The select's falling edge tells the converter to take its sample. The block then clocks the result out of the converter and returns it as a parallel word with a one-cycle strobe.

The link carries a fixed lead-in before the payload. On the first five falling serial-clock edges the reader samples lead-in levels, and the fifth of these is always a forced low. The reader throws all five away. Sixteen payload bits then follow, most significant first. The reader samples each bit on a falling edge: the converter changes its output on that same edge and holds the old level briefly, so the reader sees the bit that was set up during the previous clock period.

The converter limits both the serial clock rate and the minimum time from one sample to the next. A pacing counter therefore spaces the frames. A frame can be requested with a start pulse, or the block can launch frames by itself at a fixed rate.

Top module: `sar_frame_reader`

## Requirements
- R1: After reset, `cs_n` is high, `sclk` is low, `valid` is low and `data` is zero.
- R2: `sclk` is low whenever `cs_n` is high. A frame begins with `cs_n` falling while `sclk` is low, and the first rising `sclk` edge comes DIV_HALF system clocks later (default 10).
- R3: Each high and low phase of `sclk` lasts DIV_HALF system clocks. The default gives 2.5 MHz from a 50 MHz clock.
- R4: A frame has exactly FRAME_CLKS falling `sclk` edges (default 24). `cs_n` rises on the same system clock edge that produces the last falling `sclk` edge.
- R5: `sdata` is sampled on the system clock edge where `sclk` falls. Falling edges 1 to 5 are discarded, and the 5th carries the forced-low start level. Edges 6 to 21 carry payload bits 15 down to 0.
- R6: `valid` is high for exactly one cycle, on the same edge where `cs_n` rises, and `data` carries the assembled word at that time. `data` changes at no other time.
- R7: A `start` pulse seen while idle, once the minimum cycle has passed, pulls `cs_n` low on that same clock edge.
- R8: Two falling edges of `cs_n` are never closer than CYCLE_MIN system clocks (default 500, which is 10 µs).
- R9: A `start` that arrives during a frame, or before the minimum cycle has passed, is held rather than lost. The held frame launches exactly CYCLE_MIN clocks after the previous launch. Several such pulses merge into one frame.
- R10: While `auto_en` is high, frames launch every RATE_CLKS clocks (default 600). While it is low, no frame launches without a `start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one frame |
| auto_en | input | 1 | Launch frames from the internal rate timer |
| sdata | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low frame select and sample trigger |
| data | output | 16 | Last assembled sample |
| valid | output | 1 | One-cycle strobe marking a new `data` word |

## Verification
The converter model in the bench drives ones during the lead-in, the forced zero on the fifth edge, and then the payload. A reader that starts capturing one edge too early returns a word shifted right, with the start zero in bit 15. One that starts an edge too late loses the MSB, so all-ones and 0x8001 words expose either slip. The bench also sends a start request in the middle of a frame and another just after it. A design that dropped the held request would launch no second frame. One that ignored the pacing would shorten the cycle below 500 clocks. One that queued each pulse separately would launch a third frame. Auto mode is checked for its exact 600-clock spacing and for going silent when it is disabled.

// File: rtl/sar_rd_pkg.sv
// Shared types for the serial converter reader.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sar_rd_pkg;
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_BUSY = 1'b1
    } rd_state_t;
endpackage

// File: rtl/sar_rd_clkdiv.sv
// Half-period tick generator for the serial clock.
// Emits a one-cycle tick every HALF system clocks while en is high and
// restarts from zero whenever en is low, so the first tick of a frame
// comes exactly HALF clocks after enable.
module sar_rd_clkdiv #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(HALF - 1));

    // Count system clocks within one serial half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sar_rd_pacer.sv
// Frame launch arbiter.
// Tracks the clocks since the last launch, saturating at the longer of
// the minimum cycle and the auto rate. It holds one start request until
// the block is idle and the minimum cycle has passed. Assumes
// RATE_CLKS and CYCLE_MIN are at least the frame length.
module sar_rd_pacer #(
    parameter int CYCLE_MIN = 500,
    parameter int RATE_CLKS = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic auto_en,
    input  logic idle,
    output logic launch
);
    localparam int PERIOD = (RATE_CLKS > CYCLE_MIN) ? RATE_CLKS : CYCLE_MIN;
    localparam int PW     = $clog2(PERIOD + 1);

    logic [PW-1:0] since_q;
    logic          pend_q;
    logic          min_ok, rate_ok;

    assign min_ok  = since_q >= PW'(CYCLE_MIN);
    assign rate_ok = since_q >= PW'(RATE_CLKS);
    assign launch  = idle && ((auto_en && rate_ok) || ((start || pend_q) && min_ok));

    // Clocks since the last launch, saturating; after reset a launch is allowed at once.
    always_ff @(posedge clk) begin
        if (!rst_n)                       since_q <= PW'(PERIOD);
        else if (launch)                  since_q <= PW'(1);
        else if (since_q < PW'(PERIOD))   since_q <= since_q + 1'b1;
    end

    // Remember one start that could not launch yet; later pulses merge into it.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (launch) pend_q <= 1'b0;
        else if (start)  pend_q <= 1'b1;
    end
endmodule

// File: rtl/sar_rd_capture.sv
// Payload shifter and result register.
// Shifts sdata in MSB first on the falling edges numbered
// PRE_EDGES+1 .. PRE_EDGES+DATA_W. On the frame's last falling edge it
// loads the word, including any bit shifted on that same edge, into
// the output register with a one-cycle strobe.
module sar_rd_capture #(
    parameter int DATA_W    = 16,
    parameter int PRE_EDGES = 5,
    parameter int EDGE_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic [EDGE_W-1:0] fall_idx,
    input  logic              last,
    input  logic              sdata,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    localparam int FIRST_BIT = PRE_EDGES + 1;
    localparam int LAST_BIT  = PRE_EDGES + DATA_W;

    logic [DATA_W-1:0] shift_q, shift_d;
    logic              take;

    assign take    = fall && (fall_idx >= EDGE_W'(FIRST_BIT)) && (fall_idx <= EDGE_W'(LAST_BIT));
    assign shift_d = take ? {shift_q[DATA_W-2:0], sdata} : shift_q;

    // Accumulate payload bits.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= shift_d;
    end

    // Publish the word and strobe at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= last;
            if (last) data <= shift_d;
        end
    end
endmodule

// File: rtl/sar_frame_reader.sv
// Host-side reader for a select-framed three-wire serial converter.
// Pulls cs_n low to trigger a sample, toggles sclk every DIV_HALF
// clocks, and ends the frame on the FRAME_CLKS-th falling edge. sdata
// is taken to be stable around the sclk falling edge, so it is sampled
// without a synchroniser. Parameters must satisfy
// FRAME_CLKS >= PRE_EDGES + DATA_W.
module sar_frame_reader
    import sar_rd_pkg::*;
#(
    parameter int DIV_HALF   = 10,
    parameter int FRAME_CLKS = 24,
    parameter int PRE_EDGES  = 5,
    parameter int DATA_W     = 16,
    parameter int CYCLE_MIN  = 500,
    parameter int RATE_CLKS  = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              auto_en,
    input  logic              sdata,
    output logic              sclk,
    output logic              cs_n,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    localparam int EDGE_W = $clog2(FRAME_CLKS + 1);

    rd_state_t         state_q;
    logic              sclk_q, cs_q;
    logic [EDGE_W-1:0] edges_q, fall_idx;
    logic              tick, launch, fall, last, busy;

    assign busy     = (state_q == RD_BUSY);
    assign fall     = busy && tick && sclk_q;
    assign fall_idx = edges_q + 1'b1;
    assign last     = fall && (fall_idx == EDGE_W'(FRAME_CLKS));
    assign sclk     = sclk_q;
    assign cs_n     = cs_q;

    sar_rd_clkdiv #(.HALF(DIV_HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .tick (tick)
    );

    sar_rd_pacer #(.CYCLE_MIN(CYCLE_MIN), .RATE_CLKS(RATE_CLKS)) u_pace (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .auto_en(auto_en),
        .idle   (!busy),
        .launch (launch)
    );

    sar_rd_capture #(.DATA_W(DATA_W), .PRE_EDGES(PRE_EDGES), .EDGE_W(EDGE_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall    (fall),
        .fall_idx(fall_idx),
        .last    (last),
        .sdata   (sdata),
        .data    (data),
        .valid   (valid)
    );

    // Frame sequencer: select, serial clock phase and falling-edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            edges_q <= '0;
        end else begin
            case (state_q)
                RD_IDLE: begin
                    sclk_q <= 1'b0;
                    if (launch) begin
                        state_q <= RD_BUSY;
                        cs_q    <= 1'b0;
                        edges_q <= '0;
                    end
                end
                RD_BUSY: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        if (sclk_q) edges_q <= fall_idx;
                        if (last) begin
                            state_q <= RD_IDLE;
                            cs_q    <= 1'b1;
                        end
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_frame_reader_chk.sv
// Protocol checker for sar_frame_reader, attached by bind.
// Watches only the top-level ports and keeps its own counters for the
// frame edge count and the launch spacing.
module sar_frame_reader_chk #(
    parameter int FRAME_CLKS = 24,
    parameter int CYCLE_MIN  = 500,
    parameter int DATA_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              cs_n,
    input logic [DATA_W-1:0] data,
    input logic              valid
);
    localparam int GW = $clog2(CYCLE_MIN + 1);
    localparam int NW = $clog2(FRAME_CLKS + 1) + 1;

    logic          cs_prev, sclk_prev;
    logic [GW-1:0] gap_q;
    logic [NW-1:0] nfall_q;
    logic          cs_fell, cs_rose, sclk_fell;

    assign cs_fell   = cs_prev && !cs_n;
    assign cs_rose   = !cs_prev && cs_n;
    assign sclk_fell = sclk_prev && !sclk;

    // Previous levels of the select and the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_n;
            sclk_prev <= sclk;
        end
    end

    // Clocks since the last select fall, saturating at the minimum cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                     gap_q <= GW'(CYCLE_MIN);
        else if (cs_fell)               gap_q <= GW'(1);
        else if (gap_q < GW'(CYCLE_MIN)) gap_q <= gap_q + 1'b1;
    end

    // Falling serial-clock edges seen in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         nfall_q <= '0;
        else if (cs_fell)   nfall_q <= '0;
        else if (sclk_fell) nfall_q <= nfall_q + 1'b1;
    end

    a_r2_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r4_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rose |-> (nfall_q + NW'(sclk_fell)) == NW'(FRAME_CLKS));

    a_r6_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> cs_rose);

    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data) |-> valid);

    a_r8_min_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fell |-> gap_q >= GW'(CYCLE_MIN));
endmodule

bind sar_frame_reader sar_frame_reader_chk #(
    .FRAME_CLKS(FRAME_CLKS),
    .CYCLE_MIN (CYCLE_MIN),
    .DATA_W    (DATA_W)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (sclk),
    .cs_n (cs_n),
    .data (data),
    .valid(valid)
);

// File: tb/sar_frame_reader_test.sv
// Directed bench for sar_frame_reader with a behavioural converter model.
module sar_frame_reader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        auto_en = 1'b0;
    logic        sdata = 1'b1;
    logic        sclk, cs_n, valid;
    logic [15:0] data;

    int          n_checks = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit          done = 1'b0;
    logic [15:0] dev_word = 16'h0000;
    logic [15:0] cur_word = 16'h0000;
    int          dev_k = 0;

    sar_frame_reader uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .auto_en(auto_en),
        .sdata  (sdata),
        .sclk   (sclk),
        .cs_n   (cs_n),
        .data   (data),
        .valid  (valid)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Converter model: ones before the start bit, a forced zero, then MSB first.
    always @(negedge cs_n) begin
        cur_word = dev_word;
        dev_k    = 0;
        sdata   <= 1'b1;
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            dev_k = dev_k + 1;
            if (dev_k < 4)       sdata <= 1'b1;
            else if (dev_k == 4) sdata <= 1'b0;
            else if (dev_k <= 20) sdata <= cur_word[20 - dev_k];
            else                 sdata <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // R1: reset values.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(cs_n === 1'b1, "R1", "cs_n in reset", cs_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n === 1'b1 && sclk === 1'b0, "R1", "cs_n/sclk after reset", {cs_n, sclk}, 2);
        check(valid === 1'b0 && data === 16'h0, "R1", "valid/data after reset", data, 0);
    endtask

    // R2..R7: one started frame, timing and payload.
    task automatic t_frame(input logic [15:0] w);
        int k = 0, first_rise = -1, nfall = 0, hrun = 0, bad_hi = 0, lrun = 0, bad_lo = 0;
        logic prev;
        dev_word = w;
        pulse_start();
        check(cs_n === 1'b0, "R7", "cs_n low after start", cs_n, 0);
        check(sclk === 1'b0, "R2", "sclk low at frame start", sclk, 0);
        prev = sclk;
        while (valid !== 1'b1 && k < 2000) begin
            @(negedge clk);
            k++;
            if (sclk && !prev && first_rise < 0) first_rise = k;
            if (sclk) hrun++;
            if (!sclk && prev) begin
                nfall++;
                if (hrun != 10) bad_hi++;
                hrun = 0;
            end
            if (!sclk && first_rise >= 0 && !valid) lrun++;
            if (sclk && prev == 1'b0 && nfall > 0) begin
                if (lrun != 10) bad_lo++;
                lrun = 0;
            end
            if (sclk) lrun = 0;
            prev = sclk;
        end
        check(first_rise == 10, "R2", "cs fall to first sclk rise", first_rise, 10);
        check(bad_hi == 0 && bad_lo == 0, "R3", "half periods not 10", bad_hi + bad_lo, 0);
        check(nfall == 24, "R4", "falling edges per frame", nfall, 24);
        check(cs_n === 1'b1, "R4", "cs_n high with last edge", cs_n, 1);
        check(data === w, "R5", "captured word", data, w);
        @(negedge clk);
        check(valid === 1'b0, "R6", "valid one cycle", valid, 0);
        check(data === w, "R6", "data held after valid", data, w);
        repeat (30) @(negedge clk);
    endtask

    task automatic wait_valid(output int ok);
        int k = 0;
        while (valid !== 1'b1 && k < 3000) begin @(negedge clk); k++; end
        ok = (valid === 1'b1);
    endtask

    // R8, R9: starts during a frame are held, merged, and paced.
    task automatic t_hold();
        int t1, t2, k, ok, extra;
        dev_word = 16'h3C5A;
        pulse_start();
        t1 = cyc;
        repeat (100) @(negedge clk);
        pulse_start();
        repeat (50) @(negedge clk);
        pulse_start();
        wait_valid(ok);
        check(ok == 1 && data === 16'h3C5A, "R9", "first frame data", data, 16'h3C5A);
        dev_word = 16'hC3A5;
        k = 0;
        while (cs_n !== 1'b0 && k < 1000) begin @(negedge clk); k++; end
        t2 = cyc;
        check(t2 - t1 == 500, "R9", "held launch spacing", t2 - t1, 500);
        check(t2 - t1 >= 500, "R8", "minimum cycle", t2 - t1, 500);
        wait_valid(ok);
        check(ok == 1 && data === 16'hC3A5, "R9", "held frame data", data, 16'hC3A5);
        extra = 0;
        repeat (700) begin
            @(negedge clk);
            if (cs_n === 1'b0) extra++;
        end
        check(extra == 0, "R9", "merged requests gave extra frame", extra, 0);
    endtask

    // R10: automatic rate and silence when disabled.
    task automatic t_auto();
        int t[3];
        int n = 0, k = 0, extra = 0;
        logic prev;
        dev_word = 16'h8001;
        @(negedge clk) auto_en = 1'b1;
        prev = cs_n;
        while (n < 3 && k < 5000) begin
            @(negedge clk);
            k++;
            if (prev && !cs_n) begin t[n] = cyc; n++; end
            prev = cs_n;
        end
        auto_en = 1'b0;
        check(n == 3 && t[1] - t[0] == 600, "R10", "auto spacing 1", t[1] - t[0], 600);
        check(n == 3 && t[2] - t[1] == 600, "R10", "auto spacing 2", t[2] - t[1], 600);
        wait_valid(k);
        check(data === 16'h8001, "R10", "auto frame data", data, 16'h8001);
        repeat (5) @(negedge clk);
        repeat (900) begin
            @(negedge clk);
            if (cs_n === 1'b0) extra++;
        end
        check(extra == 0, "R10", "frames after auto off", extra, 0);
    endtask

    initial begin
        t_reset();
        t_frame(16'hA5C3);
        t_frame(16'h0000);
        t_frame(16'hFFFF);
        t_frame(16'h8001);
        t_frame(16'h1234);
        t_hold();
        t_auto();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule